// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Guard

This block watches a decoded DRAM command stream, one command per clock, and keeps an independent view of each of four banks. For every command it decides whether the command respects the row, column, refresh and mode-set spacing rules. It measures elapsed time with saturating per-bank and chip-wide age counters. Every limit is a parameter counted in clock cycles. When a command comes too early or hits a bank in the wrong state, the guard raises a one-cycle violation pulse with a code and the bank involved. It then drops that command, so its model of the memory keeps following only legal traffic.

Each bank runs a small state machine with four states. `B_IDLE` means the bank is precharged. `B_ACTIVE` means a row is open. `B_WR_AP` means the bank is recovering from a write with auto-precharge. `B_RD_AP` means it is recovering from a read with auto-precharge. The transitions are:
- idle→active on an accepted activate;
- active→idle on an accepted precharge or precharge-all;
- active→wr_ap on an accepted write with auto-precharge;
- active→rd_ap on an accepted read with auto-precharge;
- wr_ap/rd_ap→idle when the recovery window ends;
- wr_ap/rd_ap→active when an activate is accepted on the exact cycle the window ends.

Chip-wide counters track time since the last activate, refresh, mode set and write. A scheduler uses `bank_ready` to see which banks would accept an activate right now.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset no violation is reported, `bank_open` is 0000 and `bank_ready` is 1111; every timing window counts as already elapsed.
- R2: A read fewer than T_RCD_RD cycles after its bank's activate reports code 1. A write fewer than T_RCD_WR cycles after it reports code 2.
- R3: A precharge fewer than T_RAS cycles after activate reports code 4. An activate fewer than T_RP cycles after the bank's precharge reports code 3. An activate fewer than T_RC cycles after that bank's previous activate reports code 5.
- R4: An activate fewer than T_RRD cycles after any other accepted activate reports code 6.
- R5: A read to any bank before (last write cycle + BURST/2 + T_CDLR) reports code 7. This also forbids a read from cutting into a write burst.
- R6: A precharge (single or all) of a bank whose last column command was a write, before (write cycle + BURST/2 + T_WR), reports code 8.
- R7: After a write with auto-precharge, activate is blocked until write cycle + BURST/2 + T_DAL (code 9). After a read with auto-precharge, activate is blocked until read cycle + BURST/2 + T_RP (code 3). The bank then returns to idle without any command.
- R8: An activate or refresh fewer than T_RFC cycles after an accepted refresh reports code 10.
- R9: Refresh and mode set need every bank idle (code 12, else) and T_RP elapsed since each bank's precharge (code 3). Any command fewer than T_MRD cycles after a mode set reports code 11.
- R10: An activate to an open bank, a read/write to a bank that is not open, or a precharge to a bank in auto-precharge recovery reports code 13. A precharge of an idle bank is legal and changes nothing.
- R11: When several rules fail, code 11 wins, then the bank's own rules (state, RP, RC, RAS, WR, RCD, DAL, NOT_IDLE), then the chip-wide rules (RFC, RRD, WTR). An all-bank command reports the lowest-numbered failing bank.
- R12: A violating command is ignored: no bank state or timer changes because of it.
- R13: `cmd_op` encoding: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 mode set. Results appear on `viol`/`viol_code`/`viol_bank` in the cycle after the command edge. `bank_ready[i]` is high exactly when an activate to bank i would be accepted now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode (R13) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge qualifier for read/write |
| viol | output | 1 | Violation pulse for the previous command |
| viol_code | output | 4 | Violation code, 0 when none |
| viol_bank | output | 2 | Bank tied to the violation |
| bank_open | output | 4 | Bank has an open row |
| bank_ready | output | 4 | Activate to the bank would be accepted now |

## Verification
On every cycle, the assertions check three things. Every accepted activate, read and refresh actually had its chip-wide window (RRD, RFC, write-to-read) elapsed. An open bank only closes through an accepted precharge or auto-precharge. A violation never appears without a command and a ready bank is never open. The exact boundary cycles need the bench's sweeps, which move the gap between two commands across each limit on every bank. Those boundaries cover each code value, the priority between rules, the lowest-bank choice and the dropping of rejected commands.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6,
        OP_MRS  = 3'd7
    } dcg_op_e;

    typedef enum logic [3:0] {
        V_NONE     = 4'd0,
        V_RCD_RD   = 4'd1,
        V_RCD_WR   = 4'd2,
        V_RP       = 4'd3,
        V_RAS      = 4'd4,
        V_RC       = 4'd5,
        V_RRD      = 4'd6,
        V_WTR      = 4'd7,
        V_WR       = 4'd8,
        V_DAL      = 4'd9,
        V_RFC      = 4'd10,
        V_MRD      = 4'd11,
        V_NOT_IDLE = 4'd12,
        V_STATE    = 4'd13
    } dcg_viol_e;

    typedef enum logic [1:0] {
        B_IDLE   = 2'd0,
        B_ACTIVE = 2'd1,
        B_WR_AP  = 2'd2,
        B_RD_AP  = 2'd3
    } dcg_bst_e;

    function automatic int unsigned dcg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcg_timing.sv
module dcg_timing
    import dcg_pkg::*;
#(
    parameter int unsigned AGE_W  = 6,
    parameter int unsigned T_RRD  = 3,
    parameter int unsigned T_RFC  = 17,
    parameter int unsigned T_CDLR = 3,
    parameter int unsigned T_MRD  = 2,
    parameter int unsigned BEATS  = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  dcg_op_e   op,
    input  logic      apply,
    output logic      mrd_bad,
    output dcg_viol_e gcode,
    output logic      act_ok
);

    localparam logic [AGE_W-1:0] L_RRD = AGE_W'(T_RRD);
    localparam logic [AGE_W-1:0] L_RFC = AGE_W'(T_RFC);
    localparam logic [AGE_W-1:0] L_MRD = AGE_W'(T_MRD);
    localparam logic [AGE_W-1:0] L_WTR = AGE_W'(BEATS + T_CDLR);

    logic [AGE_W-1:0] age_act_q, age_ref_q, age_mrs_q, age_wr_q;

    function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
        return (a == '1) ? a : a + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_act_q <= '1;
            age_ref_q <= '1;
            age_mrs_q <= '1;
            age_wr_q  <= '1;
        end else begin
            age_act_q <= (apply && op == OP_ACT) ? AGE_W'(1) : bump(age_act_q);
            age_ref_q <= (apply && op == OP_REF) ? AGE_W'(1) : bump(age_ref_q);
            age_mrs_q <= (apply && op == OP_MRS) ? AGE_W'(1) : bump(age_mrs_q);
            age_wr_q  <= (apply && op == OP_WR)  ? AGE_W'(1) : bump(age_wr_q);
        end
    end

    always_comb begin
        mrd_bad = (op != OP_NOP) && (age_mrs_q < L_MRD);
        gcode   = V_NONE;
        unique case (op)
            OP_ACT: begin
                if (age_ref_q < L_RFC)      gcode = V_RFC;
                else if (age_act_q < L_RRD) gcode = V_RRD;
            end
            OP_RD:  if (age_wr_q < L_WTR)  gcode = V_WTR;
            OP_REF: if (age_ref_q < L_RFC) gcode = V_RFC;
            default: gcode = V_NONE;
        endcase
        act_ok = (age_ref_q >= L_RFC) && (age_act_q >= L_RRD) && (age_mrs_q >= L_MRD);
    end

    // R4
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_ACT) |-> (age_act_q >= L_RRD));

    // R8
    rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && (op == OP_ACT || op == OP_REF)) |-> (age_ref_q >= L_RFC));

    // R5
    wtr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_RD) |-> (age_wr_q >= L_WTR));

endmodule

// File: rtl/dcg_bank.sv
module dcg_bank
    import dcg_pkg::*;
#(
    parameter int unsigned AGE_W    = 6,
    parameter int unsigned T_RCD_RD = 5,
    parameter int unsigned T_RCD_WR = 3,
    parameter int unsigned T_RAS    = 10,
    parameter int unsigned T_RC     = 15,
    parameter int unsigned T_RP     = 5,
    parameter int unsigned T_WR     = 3,
    parameter int unsigned T_DAL    = 8,
    parameter int unsigned BEATS    = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  dcg_op_e   op,
    input  logic      sel,
    input  logic      ap,
    input  logic      apply,
    output dcg_viol_e code,
    output logic      is_open,
    output logic      act_ok
);

    localparam logic [AGE_W-1:0] L_RCDR = AGE_W'(T_RCD_RD);
    localparam logic [AGE_W-1:0] L_RCDW = AGE_W'(T_RCD_WR);
    localparam logic [AGE_W-1:0] L_RAS  = AGE_W'(T_RAS);
    localparam logic [AGE_W-1:0] L_RC   = AGE_W'(T_RC);
    localparam logic [AGE_W-1:0] L_RP   = AGE_W'(T_RP);
    localparam logic [AGE_W-1:0] L_WREC = AGE_W'(BEATS + T_WR);
    localparam logic [AGE_W-1:0] L_WAP  = AGE_W'(BEATS + T_DAL);
    localparam logic [AGE_W-1:0] L_RAP  = AGE_W'(BEATS + T_RP);

    dcg_bst_e         state_q, state_d;
    logic [AGE_W-1:0] age_act_q, age_pre_q, age_col_q;
    logic             lastwr_q;
    logic             go_act, go_rd, go_wr, go_pre, ap_done;
    dcg_viol_e        act_v;

    function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
        return (a == '1) ? a : a + 1'b1;
    endfunction

    assign go_act  = apply && sel && (op == OP_ACT);
    assign go_rd   = apply && sel && (op == OP_RD);
    assign go_wr   = apply && sel && (op == OP_WR);
    assign go_pre  = apply && ((sel && op == OP_PRE) || op == OP_PREA);
    assign ap_done = (state_q == B_WR_AP && age_col_q >= L_WAP) ||
                     (state_q == B_RD_AP && age_col_q >= L_RAP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE:   if (go_act) state_d = B_ACTIVE;
            B_ACTIVE: begin
                if (go_pre)                state_d = B_IDLE;
                else if (go_wr && ap)      state_d = B_WR_AP;
                else if (go_rd && ap)      state_d = B_RD_AP;
            end
            B_WR_AP, B_RD_AP:
                if (ap_done) state_d = go_act ? B_ACTIVE : B_IDLE;
        endcase
    end

    // elapsed-cycle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_act_q <= '1;
            age_pre_q <= '1;
            age_col_q <= '1;
            lastwr_q  <= 1'b0;
        end else begin
            age_act_q <= go_act ? AGE_W'(1) : bump(age_act_q);
            age_col_q <= (go_rd || go_wr) ? AGE_W'(1) : bump(age_col_q);
            if (go_pre && state_q == B_ACTIVE)
                age_pre_q <= AGE_W'(1);
            else if (state_q != B_IDLE && state_q != B_ACTIVE && state_d == B_IDLE)
                age_pre_q <= L_RP;
            else
                age_pre_q <= bump(age_pre_q);
            if (go_wr)      lastwr_q <= 1'b1;
            else if (go_rd) lastwr_q <= 1'b0;
        end
    end

    // verdicts and outputs
    always_comb begin
        act_v = V_NONE;
        unique case (state_q)
            B_IDLE: begin
                if (age_pre_q < L_RP)      act_v = V_RP;
                else if (age_act_q < L_RC) act_v = V_RC;
            end
            B_ACTIVE: act_v = V_STATE;
            B_WR_AP: begin
                if (!ap_done)              act_v = V_DAL;
                else if (age_act_q < L_RC) act_v = V_RC;
            end
            B_RD_AP: begin
                if (!ap_done)              act_v = V_RP;
                else if (age_act_q < L_RC) act_v = V_RC;
            end
        endcase

        code = V_NONE;
        unique case (op)
            OP_ACT: code = act_v;
            OP_RD: begin
                if (state_q != B_ACTIVE)    code = V_STATE;
                else if (age_act_q < L_RCDR) code = V_RCD_RD;
            end
            OP_WR: begin
                if (state_q != B_ACTIVE)    code = V_STATE;
                else if (age_act_q < L_RCDW) code = V_RCD_WR;
            end
            OP_PRE, OP_PREA: begin
                if (state_q == B_WR_AP || state_q == B_RD_AP) code = V_STATE;
                else if (state_q == B_ACTIVE) begin
                    if (age_act_q < L_RAS)                 code = V_RAS;
                    else if (lastwr_q && age_col_q < L_WREC) code = V_WR;
                end
            end
            OP_REF, OP_MRS: begin
                if (state_q != B_IDLE)     code = V_NOT_IDLE;
                else if (age_pre_q < L_RP) code = V_RP;
            end
            default: code = V_NONE;
        endcase

        is_open = (state_q == B_ACTIVE);
        act_ok  = (act_v == V_NONE);
    end

    // R12
    open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(apply && sel && op == OP_ACT));

    // R7
    close_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_open) |-> $past(apply && (op == OP_PRE || op == OP_PREA ||
                                           ((op == OP_RD || op == OP_WR) && ap))));

    // R3
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pre && state_q == B_ACTIVE) |-> (age_act_q >= L_RAS));

endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
    import dcg_pkg::*;
#(
    parameter int unsigned NBANK    = 4,
    parameter int unsigned BURST    = 4,
    parameter int unsigned T_RCD_RD = 5,
    parameter int unsigned T_RCD_WR = 3,
    parameter int unsigned T_RAS    = 10,
    parameter int unsigned T_RC     = 15,
    parameter int unsigned T_RP     = 5,
    parameter int unsigned T_RRD    = 3,
    parameter int unsigned T_RFC    = 17,
    parameter int unsigned T_WR     = 3,
    parameter int unsigned T_CDLR   = 3,
    parameter int unsigned T_DAL    = 8,
    parameter int unsigned T_MRD    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [1:0] cmd_bank,
    input  logic       cmd_ap,
    output logic       viol,
    output logic [3:0] viol_code,
    output logic [1:0] viol_bank,
    output logic [3:0] bank_open,
    output logic [3:0] bank_ready
);

    localparam int unsigned BEATS = BURST / 2;
    localparam int unsigned LIMIT =
        dcg_max(dcg_max(dcg_max(T_RC, T_RFC), dcg_max(BEATS + T_DAL, BEATS + T_RP)),
                dcg_max(dcg_max(BEATS + T_CDLR, BEATS + T_WR),
                        dcg_max(dcg_max(T_RAS, T_RCD_RD), dcg_max(T_RCD_WR, dcg_max(T_RRD, T_MRD)))));
    localparam int unsigned AGE_W = $clog2(LIMIT + 2);
    localparam int unsigned BA_W  = $clog2(NBANK);

    dcg_op_e   op;
    logic      live, apply, mrd_bad, g_act_ok, is_all;
    dcg_viol_e gcode, loc_sel, all_code, final_code;
    logic [BA_W-1:0] all_bank, final_bank;
    dcg_viol_e loc_code [NBANK];
    logic [NBANK-1:0] b_open, b_act_ok;

    dcg_viol_e       code_q;
    logic [BA_W-1:0] bank_q;
    logic            viol_q;

    assign op     = cmd_valid ? dcg_op_e'(cmd_op) : OP_NOP;
    assign live   = (op != OP_NOP);
    assign is_all = (op == OP_PREA) || (op == OP_REF) || (op == OP_MRS);

    dcg_timing #(
        .AGE_W(AGE_W), .T_RRD(T_RRD), .T_RFC(T_RFC),
        .T_CDLR(T_CDLR), .T_MRD(T_MRD), .BEATS(BEATS)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .op(op), .apply(apply),
        .mrd_bad(mrd_bad), .gcode(gcode), .act_ok(g_act_ok)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        dcg_bank #(
            .AGE_W(AGE_W), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR),
            .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR),
            .T_DAL(T_DAL), .BEATS(BEATS)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .op(op),
            .sel(cmd_bank == BA_W'(i)), .ap(cmd_ap), .apply(apply),
            .code(loc_code[i]), .is_open(b_open[i]), .act_ok(b_act_ok[i])
        );
    end

    // lowest failing bank for all-bank commands
    always_comb begin
        all_code = V_NONE;
        all_bank = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (loc_code[i] != V_NONE) begin
                all_code = loc_code[i];
                all_bank = BA_W'(i);
            end
        end
    end

    // rule priority: mode-set gap, bank-local, chip-wide
    always_comb begin
        loc_sel    = is_all ? all_code : loc_code[cmd_bank];
        final_bank = (is_all && all_code != V_NONE && !mrd_bad) ? all_bank : cmd_bank;
        if (!live)                  final_code = V_NONE;
        else if (mrd_bad)           final_code = V_MRD;
        else if (loc_sel != V_NONE) final_code = loc_sel;
        else                        final_code = gcode;
        apply = live && (final_code == V_NONE);
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            code_q <= V_NONE;
            bank_q <= '0;
        end else begin
            viol_q <= (final_code != V_NONE);
            code_q <= final_code;
            bank_q <= final_bank;
        end
    end

    assign viol       = viol_q;
    assign viol_code  = code_q;
    assign viol_bank  = bank_q;
    assign bank_open  = b_open;
    assign bank_ready = b_act_ok & {NBANK{g_act_ok}};

    // R13
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(cmd_valid));

    // R13
    ready_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ready & bank_open) == '0);

    // R12
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == OP_ACT && final_code != V_NONE && !bank_open[cmd_bank])
        |=> !bank_open[$past(cmd_bank)]);

endmodule

// File: tb/sim_dram_cmd_guard.sv
module sim_dram_cmd_guard;

    localparam int P_RCD_RD = 4, P_RCD_WR = 2, P_RAS = 6, P_RC = 10, P_RP = 3;
    localparam int P_RRD = 2, P_RFC = 7, P_WR = 2, P_CDLR = 2, P_DAL = 5, P_MRD = 2;
    localparam int P_BURST = 4, P_BEATS = P_BURST / 2;

    localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;
    localparam logic [2:0] PREA = 3'd5, REF = 3'd6, MRS = 3'd7;

    localparam int C_RCD_RD = 1, C_RCD_WR = 2, C_RP = 3, C_RAS = 4, C_RC = 5, C_RRD = 6;
    localparam int C_WTR = 7, C_WR = 8, C_DAL = 9, C_RFC = 10, C_MRD = 11, C_NIDLE = 12, C_STATE = 13;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ap = 1'b0;
    logic       viol;
    logic [3:0] viol_code;
    logic [1:0] viol_bank;
    logic [3:0] bank_open, bank_ready;

    int n_chk = 0, n_bad = 0;

    dram_cmd_guard #(
        .BURST(P_BURST), .T_RCD_RD(P_RCD_RD), .T_RCD_WR(P_RCD_WR), .T_RAS(P_RAS),
        .T_RC(P_RC), .T_RP(P_RP), .T_RRD(P_RRD), .T_RFC(P_RFC), .T_WR(P_WR),
        .T_CDLR(P_CDLR), .T_DAL(P_DAL), .T_MRD(P_MRD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .viol(viol), .viol_code(viol_code),
        .viol_bank(viol_bank), .bank_open(bank_open), .bank_ready(bank_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_v(input string req, input int code, input int b);
        n_chk++;
        if (viol !== (code != 0) || int'(viol_code) != code ||
            (code != 0 && int'(viol_bank) != b)) begin
            n_bad++;
            $display("FAIL %s: actual viol=%0d code=%0d bank=%0d expected code=%0d bank=%0d",
                     req, viol, viol_code, viol_bank, code, b);
        end
    endtask

    // entered and left at a falling edge
    task automatic go(input logic [2:0] op, input int b, input logic ap);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = b[1:0]; cmd_ap = ap;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_ap = 1'b0;
    endtask

    task automatic gap(input int d);
        repeat (d - 1) @(negedge clk);
    endtask

    task automatic rst();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst();
        // R1 reset state
        chk("R1 viol", int'(viol), 0);
        chk("R1 open", int'(bank_open), 0);
        chk("R1 ready", int'(bank_ready), 15);

        for (int b = 0; b < 4; b++) begin
            // R2 activate to read / write
            for (int d = 1; d <= P_RCD_RD + 1; d++) begin
                rst(); go(ACT, b, 0); gap(d); go(RD, b, 0);
                expect_v("R2 rcd_rd", (d < P_RCD_RD) ? C_RCD_RD : 0, b);
            end
            for (int d = 1; d <= P_RCD_WR + 1; d++) begin
                rst(); go(ACT, b, 0); gap(d); go(WR, b, 0);
                expect_v("R2 rcd_wr", (d < P_RCD_WR) ? C_RCD_WR : 0, b);
            end
            // R3 ras, rp, rc
            for (int d = 4; d <= P_RAS + 1; d++) begin
                rst(); go(ACT, b, 0); gap(d); go(PRE, b, 0);
                expect_v("R3 ras", (d < P_RAS) ? C_RAS : 0, b);
            end
            for (int d = 1; d <= P_RP + 1; d++) begin
                rst(); go(ACT, b, 0); gap(8); go(PRE, b, 0); gap(d); go(ACT, b, 0);
                expect_v("R3 rp", (d < P_RP) ? C_RP : 0, b);
            end
            for (int d = 3; d <= 5; d++) begin
                rst(); go(ACT, b, 0); gap(6); go(PRE, b, 0); gap(d); go(ACT, b, 0);
                expect_v("R3 rc", (6 + d < P_RC) ? C_RC : 0, b);
            end
            // R4 activate spacing across banks
            for (int d = 1; d <= P_RRD + 1; d++) begin
                rst(); go(ACT, b, 0); gap(d); go(ACT, (b + 1) % 4, 0);
                expect_v("R4 rrd", (d < P_RRD) ? C_RRD : 0, (b + 1) % 4);
            end
            // R5 write end to read
            for (int d = 2; d <= P_BEATS + P_CDLR + 1; d++) begin
                rst(); go(ACT, b, 0); gap(P_RCD_WR); go(WR, b, 0); gap(d); go(RD, b, 0);
                expect_v("R5 wtr", (d < P_BEATS + P_CDLR) ? C_WTR : 0, b);
            end
            // R6 write recovery before precharge
            for (int d = 1; d <= P_BEATS + P_WR + 1; d++) begin
                rst(); go(ACT, b, 0); gap(6); go(WR, b, 0); gap(d); go(PRE, b, 0);
                expect_v("R6 wr", (d < P_BEATS + P_WR) ? C_WR : 0, b);
            end
            // R7 auto-precharge windows
            for (int d = 5; d <= P_BEATS + P_DAL + 1; d++) begin
                rst(); go(ACT, b, 0); gap(6); go(WR, b, 1); gap(d); go(ACT, b, 0);
                expect_v("R7 dal", (d < P_BEATS + P_DAL) ? C_DAL : 0, b);
            end
            for (int d = 3; d <= P_BEATS + P_RP + 1; d++) begin
                rst(); go(ACT, b, 0); gap(6); go(RD, b, 1); gap(d); go(ACT, b, 0);
                expect_v("R7 rd_ap", (d < P_BEATS + P_RP) ? C_RP : 0, b);
            end
            // R8 refresh cycle time
            for (int d = 5; d <= P_RFC + 1; d++) begin
                rst(); go(REF, b, 0); gap(d); go(ACT, b, 0);
                expect_v("R8 rfc", (d < P_RFC) ? C_RFC : 0, b);
            end
            // R9 mode set gap, idle and precharge time
            for (int d = 1; d <= P_MRD + 1; d++) begin
                rst(); go(MRS, 0, 0); gap(d); go(ACT, b, 0);
                expect_v("R9 mrd", (d < P_MRD) ? C_MRD : 0, b);
            end
            rst(); go(ACT, b, 0); gap(1); go(MRS, 0, 0);
            expect_v("R9 not_idle", C_NIDLE, b);
            for (int d = 1; d <= P_RP + 1; d++) begin
                rst(); go(ACT, b, 0); gap(6); go(PREA, 0, 0); gap(d); go(MRS, 0, 0);
                expect_v("R9 rp", (d < P_RP) ? C_RP : 0, b);
            end
            // R10 wrong bank state
            rst(); go(RD, b, 0);
            expect_v("R10 rd_closed", C_STATE, b);
            rst(); go(ACT, b, 0); gap(12); go(ACT, b, 0);
            expect_v("R10 act_open", C_STATE, b);
            rst(); go(ACT, b, 0); gap(6); go(WR, b, 1); gap(1); go(PRE, b, 0);
            expect_v("R10 pre_ap", C_STATE, b);
            rst(); go(PRE, b, 0);
            expect_v("R10 pre_idle", 0, b);
            chk("R10 pre_idle open", int'(bank_open), 0);
        end

        // R7 bank returns to idle after recovery
        rst(); go(ACT, 2, 0); gap(6); go(WR, 2, 1);
        chk("R7 closed", int'(bank_open), 0);
        gap(P_BEATS + P_DAL + 1);
        chk("R7 ready", int'(bank_ready), 15);

        // R11 priority and lowest bank
        rst(); go(ACT, 1, 0); gap(P_RRD); go(ACT, 3, 0); gap(1); go(PREA, 0, 0);
        expect_v("R11 lowest", C_RAS, 1);
        rst(); go(MRS, 0, 0); gap(1); go(RD, 0, 0);
        expect_v("R11 mrd_first", C_MRD, 0);
        rst(); go(REF, 0, 0); gap(1); go(ACT, 0, 0); gap(1); go(ACT, 0, 0);
        expect_v("R11 local_before_global", C_RFC, 0);
        rst(); go(ACT, 0, 0); gap(P_RP); go(REF, 0, 0);
        expect_v("R11 refresh_not_idle", C_NIDLE, 0);

        // R12 rejected commands leave no trace
        rst(); go(ACT, 0, 0); gap(1); go(ACT, 1, 0);
        expect_v("R12 rrd", C_RRD, 1);
        chk("R12 open", int'(bank_open), 1);
        gap(P_RCD_WR + 1); go(WR, 1, 0);
        expect_v("R12 dropped", C_STATE, 1);

        // R13 ready reflects windows
        rst(); go(ACT, 0, 0);
        chk("R13 ready_rrd", int'(bank_ready), 0);
        chk("R13 open", int'(bank_open), 1);
        gap(P_RRD);
        chk("R13 ready_after", int'(bank_ready), 14);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule